// File: doc/BRIEF.md
# Stop-Mode Wake Controller

This block decides when a small microcontroller core may clock again after it has been put to sleep. Software programs one configuration byte, reached through the expanded register bank at offset 0Bh. The byte chooses the wake source and turns the post-wake settling wait on or off. It also turns on a divide-by-16 enable for the system and timer clocks. A stop request from the core gates the core clock. The block then watches the chosen wake source, which is sampled through a two-flop synchroniser. When that source is low, the block lets the clock run again, either at once or after a fixed settling count.

A sticky status bit tells software how the part last started. It reads 1 after a wake from stop and 0 after a power-on reset. The byte is write-only except for this bit, which is read-only. Every read therefore returns the status bit in bit 7 and zeros in all other bits. Power-on reset (`por`) is synchronous and active high. It is the only way to restart the block when the wake source code selects no pin.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `por`, the block is in run mode with `core_clk_en`=1. The divider is off, so `clk_div_en`=1. The wake source code is 000, the settling wait is on, and `cfg_rdata` reads 8'h00.
- R2: A `stop_req` sampled high in run mode drives `core_clk_en` to 0 after that same clock edge.
- R3: The wake source code sits in configuration bits [4:2]. Code 010 selects `aux_pin[0]`, 011 selects `aux_pin[1]`, 100 selects `aux_pin[2]` and 101 selects `port2_pin[7]`. Code 110 selects the NOR of `port2_pin[3:0]` and 111 selects the NOR of `port2_pin[7:0]`. Wake-up requires the selected source to be low, so for the NOR codes it requires any of the covered bits to be high. Lines that the code does not select never wake the block.
- R4: Codes 000 and 001 never wake the block. It stays stopped whatever the pins do, until `por`.
- R5: With the settling wait off (bit 5 = 0), a pin change made between two edges gives `core_clk_en`=1 after the third rising edge that follows: two synchroniser stages plus one state update.
- R6: With the settling wait on (bit 5 = 1), the release comes exactly 16 clock cycles later than under R5.
- R7: Bit 7 of `cfg_rdata` is set by a wake from stop, is cleared only by `por`, and cannot be written. All other read bits are 0.
- R8: A wake clears the divide bit (bit 0). If a register write lands on the same edge as the wake, the clear wins for bit 0 over the written value.
- R9: With bit 0 = 1, `clk_div_en` is a one-cycle pulse every 16 cycles. With bit 0 = 0, it stays at 1.
- R10: A write needs `cfg_we` and `cfg_sel` high on the same edge. With `cfg_sel` low the write is ignored.
- R11: Pin activity while the block is in run mode changes neither `core_clk_en` nor the status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running low-speed clock |
| por | input | 1 | Synchronous active-high power-on reset |
| stop_req | input | 1 | Core asks to enter stop mode |
| aux_pin | input | 3 | Three single-line wake candidates |
| port2_pin | input | 8 | Eight-bit port used by the single-bit and NOR wake codes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Address match for the configuration byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data, status in bit 7 |
| core_clk_en | output | 1 | Core clock enable |
| clk_div_en | output | 1 | Enable for the divided system and timer clocks |

## Verification
A wake from stop clears the divide bit, and a software write can set that same bit, so the two can fall on one edge. The bench provokes this by waiting for the second synchroniser stage to hold the low pin level, then presenting a write with bit 0 set for the very next edge. That edge is the one on which the wake is taken. The outcome is judged at the ports. `core_clk_en` and the status bit must both rise. `clk_div_en` must then stay high for 32 cycles, which shows that the hardware clear overrode the write.

// File: rtl/swr_pkg.sv
package swr_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_HOLD = 2'd2
    } swr_state_e;

    typedef enum logic [2:0] {
        SRC_NONE    = 3'b000,
        SRC_RSVD    = 3'b001,
        SRC_AUX0    = 3'b010,
        SRC_AUX1    = 3'b011,
        SRC_AUX2    = 3'b100,
        SRC_P2_TOP  = 3'b101,
        SRC_NOR_LO  = 3'b110,
        SRC_NOR_ALL = 3'b111
    } swr_src_e;

    typedef struct packed {
        logic     flag;
        logic     dly_en;
        swr_src_e src;
        logic     div_on;
    } swr_cfg_t;

    localparam int AUX_W    = 3;
    localparam int P2_W     = 8;
    localparam int BIT_DIV  = 0;
    localparam int BIT_SRC  = 2;
    localparam int BIT_DLY  = 5;
    localparam int BIT_FLAG = 7;

    function automatic logic src_can_wake(swr_src_e s);
        return !(s == SRC_NONE || s == SRC_RSVD);
    endfunction

    function automatic logic src_level(swr_src_e s, logic [AUX_W-1:0] aux,
                                       logic [P2_W-1:0] p2);
        logic lvl;
        case (s)
            SRC_AUX0:    lvl = aux[0];
            SRC_AUX1:    lvl = aux[1];
            SRC_AUX2:    lvl = aux[2];
            SRC_P2_TOP:  lvl = p2[P2_W-1];
            SRC_NOR_LO:  lvl = ~|p2[3:0];
            SRC_NOR_ALL: lvl = ~|p2;
            default:     lvl = 1'b1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
    parameter int           WIDTH  = 1,
    parameter int           STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             por,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (por) chain <= {STAGES{RST_VAL[b]}};
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/swr_cfg_reg.sv
module swr_cfg_reg
    import swr_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  logic     wr_en,
    input  logic [7:0] wdata,
    input  logic     wake_evt,
    output swr_cfg_t cfg,
    output logic [7:0] rdata
);
    logic unused_rsvd;
    assign unused_rsvd = ^{wdata[BIT_FLAG], wdata[6], wdata[1]};

    always_ff @(posedge clk) begin
        if (por) begin
            cfg.flag   <= 1'b0;
            cfg.dly_en <= 1'b1;
            cfg.src    <= SRC_NONE;
            cfg.div_on <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg.dly_en <= wdata[BIT_DLY];
                cfg.src    <= swr_src_e'(wdata[BIT_SRC+2:BIT_SRC]);
            end
            if (wake_evt)   cfg.div_on <= 1'b0;
            else if (wr_en) cfg.div_on <= wdata[BIT_DIV];
            if (wake_evt)   cfg.flag <= 1'b1;
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[BIT_FLAG] = cfg.flag;
    end
endmodule

// File: rtl/swr_seq.sv
module swr_seq
    import swr_pkg::*;
#(
    parameter int DELAY_CYCLES = 16,
    localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          por,
    input  logic          stop_req,
    input  logic          wake_req,
    input  logic          dly_en,
    output swr_state_e    state,
    output logic          wake_evt,
    output logic [CW-1:0] dly_cnt
);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    assign wake_evt = (state == ST_STOP) && wake_req;

    always_ff @(posedge clk) begin
        if (por) begin
            state   <= ST_RUN;
            dly_cnt <= '0;
        end else begin
            case (state)
                ST_RUN: if (stop_req) state <= ST_STOP;
                ST_STOP: if (wake_req) begin
                    dly_cnt <= '0;
                    state   <= dly_en ? ST_HOLD : ST_RUN;
                end
                ST_HOLD: begin
                    if (dly_cnt == LAST) state <= ST_RUN;
                    else                 dly_cnt <= dly_cnt + 1'b1;
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/swr_prescale.sv
module swr_prescale #(
    parameter int RATIO = 16,
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic clk,
    input  logic por,
    input  logic div_on,
    output logic tick_en
);
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (por)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick_en = div_on ? (cnt == LAST) : 1'b1;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swr_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_CYCLES = 16,
    parameter int DIV_RATIO    = 16
) (
    input  logic             clk,
    input  logic             por,
    input  logic             stop_req,
    input  logic [AUX_W-1:0] aux_pin,
    input  logic [P2_W-1:0]  port2_pin,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output logic             core_clk_en,
    output logic             clk_div_en
);
    localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;

    logic [AUX_W-1:0] aux_s;
    logic [P2_W-1:0]  p2_s;
    swr_cfg_t         cfg;
    swr_state_e       state;
    logic             wake_evt, wake_req;
    logic [CW-1:0]    dly_cnt;

    swr_sync #(.WIDTH(AUX_W), .STAGES(SYNC_STAGES), .RST_VAL({AUX_W{1'b1}})) u_sync_aux (
        .clk(clk), .por(por), .d(aux_pin), .q(aux_s));

    swr_sync #(.WIDTH(P2_W), .STAGES(SYNC_STAGES), .RST_VAL({P2_W{1'b0}})) u_sync_p2 (
        .clk(clk), .por(por), .d(port2_pin), .q(p2_s));

    assign wake_req = src_can_wake(cfg.src) && !src_level(cfg.src, aux_s, p2_s);

    swr_cfg_reg u_cfg (
        .clk(clk), .por(por), .wr_en(cfg_we && cfg_sel), .wdata(cfg_wdata),
        .wake_evt(wake_evt), .cfg(cfg), .rdata(cfg_rdata));

    swr_seq #(.DELAY_CYCLES(DELAY_CYCLES)) u_seq (
        .clk(clk), .por(por), .stop_req(stop_req), .wake_req(wake_req),
        .dly_en(cfg.dly_en), .state(state), .wake_evt(wake_evt), .dly_cnt(dly_cnt));

    swr_prescale #(.RATIO(DIV_RATIO)) u_pre (
        .clk(clk), .por(por), .div_on(cfg.div_on), .tick_en(clk_div_en));

    assign core_clk_en = (state == ST_RUN);
endmodule

// File: rtl/stop_wake_ctrl_chk.sv
module stop_wake_ctrl_chk
    import swr_pkg::*;
#(
    parameter int DELAY_CYCLES = 16,
    localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1
) (
    input logic          clk,
    input logic          por,
    input logic          stop_req,
    input logic          core_clk_en,
    input logic          clk_div_en,
    input logic [7:0]    cfg_rdata,
    input swr_state_e    state,
    input logic [CW-1:0] dly_cnt,
    input swr_cfg_t      cfg
);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    assert_stop_gates_R2: assert property (@(posedge clk) disable iff (por)
        core_clk_en && stop_req |=> !core_clk_en);

    assert_dead_codes_R4: assert property (@(posedge clk) disable iff (por)
        (state == ST_STOP) && !src_can_wake(cfg.src) |=> state == ST_STOP);

    assert_hold_length_R6: assert property (@(posedge clk) disable iff (por)
        $rose(core_clk_en) && $past(state) == ST_HOLD |-> $past(dly_cnt) == LAST);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (por)
        !$fell(cfg_rdata[BIT_FLAG]));

    assert_flag_origin_R7: assert property (@(posedge clk) disable iff (por)
        $rose(cfg_rdata[BIT_FLAG]) |-> $past(state) == ST_STOP);

    assert_div_pulse_R9: assert property (@(posedge clk) disable iff (por)
        cfg.div_on && clk_div_en |=> !clk_div_en || !cfg.div_on);
endmodule

bind stop_wake_ctrl stop_wake_ctrl_chk #(.DELAY_CYCLES(DELAY_CYCLES)) u_chk (
    .clk(clk), .por(por), .stop_req(stop_req), .core_clk_en(core_clk_en),
    .clk_div_en(clk_div_en), .cfg_rdata(cfg_rdata), .state(state),
    .dly_cnt(dly_cnt), .cfg(cfg));

// File: tb/stop_wake_ctrl_test.sv
`timescale 1ns/1ps
module stop_wake_ctrl_test;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       stop_req = 1'b0;
    logic [2:0] aux_pin = 3'b111;
    logic [7:0] port2_pin = 8'h00;
    logic       cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       core_clk_en, clk_div_en;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    stop_wake_ctrl uut (
        .clk(clk), .por(por), .stop_req(stop_req), .aux_pin(aux_pin),
        .port2_pin(port2_pin), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .core_clk_en(core_clk_en), .clk_div_en(clk_div_en));

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_por();
        por = 1'b1; stop_req = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0;
        aux_pin = 3'b111; port2_pin = 8'h00;
        tick(2);
        por = 1'b0;
        tick(1);
    endtask

    task automatic wr(logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0; cfg_sel = 1'b0;
    endtask

    task automatic go_stop();
        stop_req = 1'b1;
        tick(1);
        stop_req = 1'b0;
    endtask

    task automatic count_div(int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (clk_div_en) highs++;
        end
    endtask

    task automatic t_reset();
        do_por();
        chk("R1", "core_clk_en", core_clk_en, 1);
        chk("R1", "clk_div_en", clk_div_en, 1);
        chk("R1", "cfg_rdata", cfg_rdata, 8'h00);
        go_stop();
        chk("R2", "gated after stop", core_clk_en, 0);
        aux_pin = 3'b000; port2_pin = 8'hFF;
        tick(30);
        chk("R4", "code 000 stays stopped", core_clk_en, 0);
    endtask

    task automatic t_reserved_code();
        do_por();
        wr(8'h04);
        go_stop();
        aux_pin = 3'b000; port2_pin = 8'hF0;
        tick(40);
        chk("R4", "code 001 stays stopped", core_clk_en, 0);
        chk("R4", "flag stays clear", cfg_rdata, 8'h00);
        do_por();
        chk("R1", "por restarts", core_clk_en, 1);
    endtask

    task automatic t_codes();
        for (int code = 2; code < 8; code++) begin
            logic [2:0] idle_a, dec_a, act_a;
            logic [7:0] idle_p, dec_p, act_p;
            idle_a = 3'b111; idle_p = (code >= 6) ? 8'h00 : 8'h80;
            dec_a = 3'b000; dec_p = idle_p;
            act_a = idle_a; act_p = idle_p;
            case (code)
                2: begin dec_a = 3'b101; act_a = 3'b110; end
                3: begin dec_a = 3'b011; act_a = 3'b101; end
                4: begin dec_a = 3'b110; act_a = 3'b011; end
                5: act_p = 8'h00;
                6: begin dec_p = 8'h30; act_p = 8'h04; end
                default: act_p = 8'h40;
            endcase
            do_por();
            wr(8'(code << 2));
            aux_pin = idle_a; port2_pin = idle_p;
            tick(3);
            go_stop();
            aux_pin = dec_a; port2_pin = dec_p;
            tick(6);
            chk("R3", $sformatf("code %0d unselected lines", code), core_clk_en, 0);
            aux_pin = act_a; port2_pin = act_p;
            if (code == 4) aux_pin = 3'b010;
            tick(2);
            chk("R5", $sformatf("code %0d not yet released", code), core_clk_en, 0);
            tick(1);
            chk("R3", $sformatf("code %0d released", code), core_clk_en, 1);
            chk("R7", $sformatf("code %0d flag", code), cfg_rdata, 8'h80);
        end
    endtask

    task automatic t_delay();
        do_por();
        wr(8'h28);
        aux_pin = 3'b111; tick(3);
        go_stop();
        aux_pin = 3'b110;
        tick(18);
        chk("R6", "still held", core_clk_en, 0);
        chk("R7", "flag set at wake", cfg_rdata, 8'h80);
        tick(1);
        chk("R6", "released after 16 extra", core_clk_en, 1);
        go_stop();
        wr(8'h80);
        chk("R7", "flag not writable", cfg_rdata, 8'h80);
        do_por();
        chk("R7", "por clears flag", cfg_rdata, 8'h00);
        wr(8'hFF);
        chk("R7", "write of bit 7 ignored", cfg_rdata, 8'h00);
    endtask

    task automatic t_divider();
        int h;
        do_por();
        wr(8'h01);
        count_div(32, h);
        chk("R9", "pulses in 32 cycles", h, 2);
        wr(8'h00);
        count_div(32, h);
        chk("R9", "constant when off", h, 32);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h01;
        tick(1);
        cfg_we = 1'b0;
        count_div(32, h);
        chk("R10", "write without select", h, 32);
        cfg_we = 1'b0; cfg_sel = 1'b1; cfg_wdata = 8'h01;
        tick(1);
        cfg_sel = 1'b0;
        count_div(32, h);
        chk("R10", "select without strobe", h, 32);
    endtask

    task automatic t_run_pins();
        do_por();
        wr(8'h08);
        aux_pin = 3'b000; port2_pin = 8'hFF;
        tick(12);
        chk("R11", "run unaffected", core_clk_en, 1);
        chk("R11", "flag unaffected", cfg_rdata, 8'h00);
    endtask

    task automatic t_collision();
        int h;
        do_por();
        wr(8'h09);
        count_div(32, h);
        chk("R9", "divider on before stop", h, 2);
        aux_pin = 3'b111; tick(3);
        go_stop();
        aux_pin = 3'b110;
        tick(2);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h09;
        tick(1);
        cfg_we = 1'b0; cfg_sel = 1'b0;
        chk("R8", "woke on collision edge", core_clk_en, 1);
        chk("R8", "flag on collision edge", cfg_rdata, 8'h80);
        count_div(32, h);
        chk("R8", "divider cleared by wake", h, 32);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_reserved_code();
        t_codes();
        t_delay();
        t_divider();
        t_run_pins();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule